// File: doc/BRIEF.md
# Eight-Channel Timer Bank Register Front End

This block is the register-facing side of a bank of eight timer channels. A 32-bit port with a single-cycle write strobe and a one-cycle-latency read reaches three groups of registers. Each channel has a window of four words. One shared control word holds a four-bit field per channel. A second control word is accepted at the port and has no effect. The counters themselves live outside the block. The block forwards status loads to them, reads their live count back, exposes each channel's reload value, and turns each channel's expiry pulse into a toggling interrupt line.

Channel windows are split into two areas of the offset space. Channels 0 to 2 sit below the control words, and channels 3 to 7 sit above them. Every offset that maps to nothing reads as zero and drops writes.

A write to the control word does not reach the channel outputs at once. A short fixed sequence applies it instead. Running channels being switched off stop first. Changed configuration bits follow. Channels being switched on start last. Only the fields that differ from the previous control value are acted on.

Top module: `tmr_bank_regs`

## Requirements
- R1: After reset, the control word reads 0, and every run, clock-select, overflow-enable, pulse, load and interrupt output is 0. Every reload output is also 0.
- R2: For word-aligned offsets 0x00 to 0x2C, the channel is offset>>4 and the register is offset bits [3:2]. Register 0 is the live count (write = load), 1 is reload, 2 is match A and 3 is match B. Reload and match registers read back what was written.
- R3: For word-aligned offsets 0x40 to 0x8C, the channel is (offset>>4)-1, so channels 3 to 7 are reached. The register select is the same as in R2.
- R4: Non-word-aligned offsets are illegal. So are 0x38 and 0x3C, and every offset above 0x8C or between 0x8C and 0x40 not listed. An illegal offset reads 0, and a write to it changes no register or output.
- R5: Offset 0x30 is the control word. Channel n owns bits [4n+3:4n]: bit 0 enable, bit 1 external clock select, bit 2 overflow interrupt enable, bit 3 pulse mode. A read returns the last accepted value.
- R6: Offset 0x34 is the second control word. It always reads 0, and a write to it changes no output.
- R7: Take a control write sampled at clock edge E1. Channels whose enable goes 1 to 0 drop their run output at edge E2. Changed clock, overflow and pulse bits update their outputs at edge E3. Channels whose enable goes 0 to 1 raise their run output at edge E4. Unchanged fields keep their outputs throughout.
- R8: A control write sampled at edges E2 to E4 of a sequence that is still running is dropped. The control word keeps the earlier value.
- R9: The pulse output of channels 0 to 3 stays 0 even when their pulse bit is set. Channels 4 to 7 follow their pulse bit.
- R10: A count write to a running channel pulses that channel's load output for one cycle, one edge after the write. The load value output carries the written data. The strobe is not raised for a stopped channel. A count read returns that channel's count input.
- R11: On an expiry pulse, a channel's interrupt line toggles when the channel is running and either overflow interrupt is enabled or match A or match B holds zero. Otherwise the line holds.
- R12: Read data updates at the edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 12 | Byte offset into the bank |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one edge after rd_en |
| cnt_i | input | 256 | Live count of each channel, 32 bits per channel |
| expire_i | input | 8 | Expiry pulse per channel |
| run_o | output | 8 | Applied run state per channel |
| extclk_o | output | 8 | Applied external clock select per channel |
| ovfie_o | output | 8 | Applied overflow interrupt enable per channel |
| pulse_o | output | 8 | Applied pulse mode per channel |
| load_o | output | 8 | Count load strobe per channel |
| load_val_o | output | 32 | Value for a count load |
| reload_o | output | 256 | Reload value of each channel, 32 bits per channel |
| irq_o | output | 8 | Toggling interrupt line per channel |

## Verification
If the stored control word and the applied per-channel state go out of step, the run or configuration outputs show it three edges after a control write at the latest. Checking those outputs edge by edge during each sequence catches ordering mistakes. Such mistakes include a disable that lands after reconfiguration, or an enable that comes early, and they show up in the single cycle where they happen. Decoding errors show up on the next read of a neighbouring window, or through a reload output that changed without a legal write. Interrupt level faults show up on the expiry pulse that follows.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    localparam int ADDR_W = 12;
    localparam int CTL_W  = 4;

    localparam logic [ADDR_W-1:0] LO_LAST   = 12'h02C;
    localparam logic [ADDR_W-1:0] CTRL_OFF  = 12'h030;
    localparam logic [ADDR_W-1:0] CTRL2_OFF = 12'h034;
    localparam logic [ADDR_W-1:0] HI_FIRST  = 12'h040;
    localparam logic [ADDR_W-1:0] HI_LAST   = 12'h08C;

    typedef struct packed {
        logic pulse;
        logic ovf_ie;
        logic ext_clk;
        logic en;
    } ch_ctl_t;

    typedef enum logic [2:0] {
        ACC_CHAN,
        ACC_CTRL,
        ACC_CTRL2,
        ACC_BAD
    } acc_kind_t;

    typedef enum logic [1:0] {
        CR_COUNT  = 2'd0,
        CR_RELOAD = 2'd1,
        CR_MATCHA = 2'd2,
        CR_MATCHB = 2'd3
    } chreg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_STOP,
        SEQ_CFG,
        SEQ_START
    } seq_t;

    typedef struct packed {
        acc_kind_t  kind;
        logic [2:0] ch;
        chreg_t     rsel;
    } dec_t;

    function automatic dec_t decode_off(input logic [ADDR_W-1:0] a);
        dec_t       d;
        logic [3:0] hi_idx;
        d.kind = ACC_BAD;
        d.ch   = 3'd0;
        d.rsel = CR_COUNT;
        hi_idx = a[7:4] - 4'd1;
        if (a[1:0] == 2'b00) begin
            if (a <= LO_LAST) begin
                d.kind = ACC_CHAN;
                d.ch   = {1'b0, a[5:4]};
                d.rsel = chreg_t'(a[3:2]);
            end else if (a == CTRL_OFF) begin
                d.kind = ACC_CTRL;
            end else if (a == CTRL2_OFF) begin
                d.kind = ACC_CTRL2;
            end else if (a >= HI_FIRST && a <= HI_LAST) begin
                d.kind = ACC_CHAN;
                d.ch   = hi_idx[2:0];
                d.rsel = chreg_t'(a[3:2]);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/tbr_decode.sv
module tbr_decode
    import tbr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output dec_t              dec,
    output logic              wr_chan,
    output logic              wr_ctrl,
    output logic              rd_any
);
    always_comb begin
        dec     = decode_off(addr);
        wr_chan = wr_en && (dec.kind == ACC_CHAN);
        wr_ctrl = wr_en && (dec.kind == ACC_CTRL);
        rd_any  = rd_en;
    end
endmodule

// File: rtl/tbr_ctrl_seq.sv
module tbr_ctrl_seq
    import tbr_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int PULSE_FIRST = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_ctrl,
    input  logic [NCH*CTL_W-1:0]  wdata,
    output logic [NCH*CTL_W-1:0]  ctrl_q,
    output seq_t                  state_q,
    output logic [NCH-1:0]        run_q,
    output logic [NCH-1:0]        ext_q,
    output logic [NCH-1:0]        ovf_q,
    output logic [NCH-1:0]        pulse_q
);
    localparam int CW = NCH * CTL_W;

    logic [CW-1:0]  old_q;
    ch_ctl_t        old_c [NCH];
    ch_ctl_t        new_c [NCH];
    logic [NCH-1:0] stop_m, start_m, ext_flip, ovf_flip, pulse_flip, pulse_ok;

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        assign old_c[g]      = old_q[g*CTL_W +: CTL_W];
        assign new_c[g]      = ctrl_q[g*CTL_W +: CTL_W];
        assign stop_m[g]     = old_c[g].en & ~new_c[g].en;
        assign start_m[g]    = ~old_c[g].en & new_c[g].en;
        assign ext_flip[g]   = old_c[g].ext_clk ^ new_c[g].ext_clk;
        assign ovf_flip[g]   = old_c[g].ovf_ie ^ new_c[g].ovf_ie;
        assign pulse_flip[g] = old_c[g].pulse ^ new_c[g].pulse;
        assign pulse_ok[g]   = (g >= PULSE_FIRST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            old_q   <= '0;
            ctrl_q  <= '0;
            run_q   <= '0;
            ext_q   <= '0;
            ovf_q   <= '0;
            pulse_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (wr_ctrl) begin
                        old_q   <= ctrl_q;
                        ctrl_q  <= wdata;
                        state_q <= SEQ_STOP;
                    end
                end
                SEQ_STOP: begin
                    run_q   <= run_q & ~stop_m;
                    state_q <= SEQ_CFG;
                end
                SEQ_CFG: begin
                    ext_q   <= ext_q ^ ext_flip;
                    ovf_q   <= ovf_q ^ ovf_flip;
                    pulse_q <= pulse_q ^ (pulse_flip & pulse_ok);
                    state_q <= SEQ_START;
                end
                SEQ_START: begin
                    run_q   <= run_q | start_m;
                    state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tbr_chan.sv
module tbr_chan
    import tbr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_sel,
    input  chreg_t        rsel,
    input  logic [DW-1:0] wdata,
    input  logic          run,
    input  logic          ovf_ie,
    input  logic          expire,
    input  logic [DW-1:0] cnt,
    output logic [DW-1:0] rd_val,
    output logic          load,
    output logic [DW-1:0] reload,
    output logic          irq
);
    logic [DW-1:0] mat_a_q, mat_b_q;
    logic          fire;

    assign fire = expire && run && (ovf_ie || mat_a_q == '0 || mat_b_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload  <= '0;
            mat_a_q <= '0;
            mat_b_q <= '0;
            load    <= 1'b0;
            irq     <= 1'b0;
        end else begin
            load <= 1'b0;
            if (wr_sel) begin
                unique case (rsel)
                    CR_COUNT:  load    <= run;
                    CR_RELOAD: reload  <= wdata;
                    CR_MATCHA: mat_a_q <= wdata;
                    CR_MATCHB: mat_b_q <= wdata;
                    default: ;
                endcase
            end
            if (fire) begin
                irq <= ~irq;
            end
        end
    end

    always_comb begin
        unique case (rsel)
            CR_COUNT:  rd_val = cnt;
            CR_RELOAD: rd_val = reload;
            CR_MATCHA: rd_val = mat_a_q;
            CR_MATCHB: rd_val = mat_b_q;
            default:   rd_val = '0;
        endcase
    end
endmodule

// File: rtl/tmr_bank_regs.sv
module tmr_bank_regs
    import tbr_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int DW          = 32,
    parameter int PULSE_FIRST = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NCH*DW-1:0] cnt_i,
    input  logic [NCH-1:0]    expire_i,
    output logic [NCH-1:0]    run_o,
    output logic [NCH-1:0]    extclk_o,
    output logic [NCH-1:0]    ovfie_o,
    output logic [NCH-1:0]    pulse_o,
    output logic [NCH-1:0]    load_o,
    output logic [DW-1:0]     load_val_o,
    output logic [NCH*DW-1:0] reload_o,
    output logic [NCH-1:0]    irq_o
);
    localparam int CW = NCH * CTL_W;

    dec_t          dec;
    logic          wr_chan, wr_ctrl, rd_any;
    logic [CW-1:0] ctrl_q;
    seq_t          seq_state;
    logic [DW-1:0] chan_rd [NCH];
    logic [DW-1:0] rd_next;

    tbr_decode u_dec (
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .dec     (dec),
        .wr_chan (wr_chan),
        .wr_ctrl (wr_ctrl),
        .rd_any  (rd_any)
    );

    tbr_ctrl_seq #(.NCH(NCH), .PULSE_FIRST(PULSE_FIRST)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wdata   (wdata[CW-1:0]),
        .ctrl_q  (ctrl_q),
        .state_q (seq_state),
        .run_q   (run_o),
        .ext_q   (extclk_o),
        .ovf_q   (ovfie_o),
        .pulse_q (pulse_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tbr_chan #(.DW(DW)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .wr_sel (wr_chan && (32'(dec.ch) == g)),
            .rsel   (dec.rsel),
            .wdata  (wdata),
            .run    (run_o[g]),
            .ovf_ie (ovfie_o[g]),
            .expire (expire_i[g]),
            .cnt    (cnt_i[g*DW +: DW]),
            .rd_val (chan_rd[g]),
            .load   (load_o[g]),
            .reload (reload_o[g*DW +: DW]),
            .irq    (irq_o[g])
        );
    end

    always_comb begin
        unique case (dec.kind)
            ACC_CHAN:  rd_next = chan_rd[dec.ch];
            ACC_CTRL:  rd_next = DW'(ctrl_q);
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata      <= '0;
            load_val_o <= '0;
        end else begin
            if (rd_any) begin
                rdata <= rd_next;
            end
            if (wr_chan && dec.rsel == CR_COUNT) begin
                load_val_o <= wdata;
            end
        end
    end
endmodule

// File: rtl/tbr_bank_chk.sv
module tbr_bank_chk
    import tbr_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int DW          = 32,
    parameter int PULSE_FIRST = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DW-1:0]        rdata,
    input logic [NCH-1:0]       expire_i,
    input logic [NCH-1:0]       run_o,
    input logic [NCH-1:0]       extclk_o,
    input logic [NCH-1:0]       ovfie_o,
    input logic [NCH-1:0]       pulse_o,
    input logic [NCH-1:0]       irq_o,
    input seq_t                 seq_state,
    input logic [NCH*CTL_W-1:0] ctrl_q
);
    logic [NCH-1:0] low_mask;
    for (genvar g = 0; g < NCH; g++) begin : g_m
        assign low_mask[g] = (g < PULSE_FIRST);
    end

    AST_RUN_FALL_IN_STOP: assert property (@(posedge clk) disable iff (rst)
        ((~run_o & $past(run_o)) != '0) |-> ($past(seq_state) == SEQ_STOP)); // R7
    AST_RUN_RISE_IN_START: assert property (@(posedge clk) disable iff (rst)
        ((run_o & ~$past(run_o)) != '0) |-> ($past(seq_state) == SEQ_START)); // R7
    AST_CFG_MOVES_IN_CFG: assert property (@(posedge clk) disable iff (rst)
        (extclk_o != $past(extclk_o) || ovfie_o != $past(ovfie_o) || pulse_o != $past(pulse_o))
        |-> ($past(seq_state) == SEQ_CFG)); // R7
    AST_SEQ_STOP_TO_CFG: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SEQ_STOP) |=> (seq_state == SEQ_CFG)); // R7
    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CTRL_OFF && seq_state != SEQ_IDLE) |=> $stable(ctrl_q)); // R8
    AST_LOW_PULSE_OFF: assert property (@(posedge clk) disable iff (rst)
        ((pulse_o & low_mask) == '0)); // R9
    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && decode_off(addr).kind == ACC_BAD) |=> (rdata == '0)); // R4
    AST_CTRL2_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == CTRL2_OFF) |=> (rdata == '0)); // R6
    AST_IRQ_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        (((irq_o ^ $past(irq_o)) & ~$past(expire_i & run_o)) == '0)); // R11
endmodule

bind tmr_bank_regs tbr_bank_chk #(.NCH(NCH), .DW(DW), .PULSE_FIRST(PULSE_FIRST)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .expire_i  (expire_i),
    .run_o     (run_o),
    .extclk_o  (extclk_o),
    .ovfie_o   (ovfie_o),
    .pulse_o   (pulse_o),
    .irq_o     (irq_o),
    .seq_state (seq_state),
    .ctrl_q    (ctrl_q)
);

// File: tb/tmr_bank_regs_bench.sv
module tmr_bank_regs_bench;
    localparam int NCH = 8;
    localparam int DW  = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0]       addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic [NCH*DW-1:0] cnt_i;
    logic [NCH-1:0]    expire_i = '0;
    logic [NCH-1:0]    run_o, extclk_o, ovfie_o, pulse_o, load_o, irq_o;
    logic [DW-1:0]     load_val_o;
    logic [NCH*DW-1:0] reload_o;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic          rd_seen = 1'b0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < NCH; g++) begin : g_cnt
        assign cnt_i[g*DW +: DW] = 32'hC0DE_0000 + g;
    end

    tmr_bank_regs u_tmr_bank_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_i(cnt_i), .expire_i(expire_i),
        .run_o(run_o), .extclk_o(extclk_o), .ovfie_o(ovfie_o), .pulse_o(pulse_o),
        .load_o(load_o), .load_val_o(load_val_o), .reload_o(reload_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [DW-1:0] e, input string tag);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expire(input logic [NCH-1:0] m);
        expire_i = m;
        @(negedge clk);
        expire_i = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, rdata, e);
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 run", 32'(run_o), 0);
        chk("R1 cfg", 32'({extclk_o, ovfie_o, pulse_o}), 0);
        chk("R1 irq/load", 32'({irq_o, load_o}), 0);
        chk("R1 reload ch7", reload_o[7*DW +: DW], 0);
        rd(12'h030, 0, "R1 ctrl");

        // R2 low window
        wr(12'h014, 32'h1111_0001);
        wr(12'h008, 32'hAAAA_0000);
        wr(12'h02C, 32'h2222_BBBB);
        rd(12'h014, 32'h1111_0001, "R2 ch1 reload");
        rd(12'h008, 32'hAAAA_0000, "R2 ch0 matchA");
        rd(12'h02C, 32'h2222_BBBB, "R2 ch2 matchB");
        rd(12'h020, 32'hC0DE_0002, "R10 ch2 count");
        chk("R2 reload_o ch1", reload_o[1*DW +: DW], 32'h1111_0001);

        // R3 high window
        wr(12'h044, 32'h3333_0003);
        wr(12'h084, 32'h7777_0007);
        wr(12'h068, 32'h5555_AAAA);
        rd(12'h044, 32'h3333_0003, "R3 ch3 reload");
        rd(12'h084, 32'h7777_0007, "R3 ch7 reload");
        rd(12'h068, 32'h5555_AAAA, "R3 ch5 matchA");
        rd(12'h040, 32'hC0DE_0003, "R3 ch3 count");
        rd(12'h080, 32'hC0DE_0007, "R3 ch7 count");
        chk("R3 reload_o ch3", reload_o[3*DW +: DW], 32'h3333_0003);
        chk("R3 reload_o ch7", reload_o[7*DW +: DW], 32'h7777_0007);

        // R4 illegal offsets
        wr(12'h038, 32'hFFFF_FFFF);
        wr(12'h03C, 32'hFFFF_FFFF);
        wr(12'h090, 32'hFFFF_FFFF);
        wr(12'h130, 32'hFFFF_FFFF);
        wr(12'h046, 32'h0000_DEAD);
        rd(12'h038, 0, "R4 0x38");
        rd(12'h03C, 0, "R4 0x3C");
        rd(12'h090, 0, "R4 0x90");
        rd(12'h045, 0, "R4 misaligned");
        rd(12'h044, 32'h3333_0003, "R4 ch3 reload kept");
        rd(12'h030, 0, "R4 ctrl kept");
        chk("R4 reload_o ch3 kept", reload_o[3*DW +: DW], 32'h3333_0003);
        chk("R4 run kept", 32'(run_o), 0);

        // R6 second control word
        wr(12'h034, 32'hFFFF_FFFF);
        rd(12'h034, 0, "R6 ctrl2");
        chk("R6 run", 32'(run_o), 0);

        // R7 enable channel 0
        wr(12'h030, 32'h0000_0001);
        chk("R7 E1 run", 32'(run_o), 0);
        idle(1); chk("R7 E2 run", 32'(run_o), 0);
        idle(1); chk("R7 E3 run", 32'(run_o), 0);
        idle(1); chk("R7 E4 run", 32'(run_o), 32'h01);
        rd(12'h030, 32'h0000_0001, "R5 ctrl");

        // R7 disable with reconfiguration
        wr(12'h030, 32'h0000_0006);
        chk("R7 dis E1 run", 32'(run_o), 32'h01);
        idle(1); chk("R7 dis E2 run", 32'(run_o), 0);
        chk("R7 dis E2 ext", 32'(extclk_o), 0);
        idle(1); chk("R7 dis E3 ext", 32'(extclk_o), 32'h01);
        chk("R7 dis E3 ovf", 32'(ovfie_o), 32'h01);
        idle(1); chk("R7 dis E4 run", 32'(run_o), 0);

        // R7 enable only
        wr(12'h030, 32'h0000_0007);
        idle(2); chk("R7 en E3 run", 32'(run_o), 0);
        idle(1); chk("R7 en E4 run", 32'(run_o), 32'h01);
        chk("R7 en ext held", 32'(extclk_o), 32'h01);

        // R7/R9 multi-channel with pulse
        wr(12'h030, 32'h00F0_00B7);
        chk("R7 mc E1 pulse", 32'(pulse_o), 0);
        idle(1); chk("R7 mc E2 run", 32'(run_o), 32'h01);
        idle(1); chk("R7 mc E3 ext", 32'(extclk_o), 32'h23);
        chk("R7 mc E3 ovf", 32'(ovfie_o), 32'h21);
        chk("R9 pulse low ch blocked", 32'(pulse_o), 32'h20);
        chk("R7 mc E3 run", 32'(run_o), 32'h01);
        idle(1); chk("R7 mc E4 run", 32'(run_o), 32'h23);

        // R8 write during sequence dropped
        wr(12'h030, 32'h0000_0007);
        wr(12'h030, 32'hFFFF_FFFF);
        idle(3);
        rd(12'h030, 32'h0000_0007, "R8 ctrl");
        chk("R8 run", 32'(run_o), 32'h01);
        chk("R8 pulse", 32'(pulse_o), 0);
        chk("R8 ext", 32'(extclk_o), 32'h01);

        // R10 load strobe
        wr(12'h000, 32'h1234_5678);
        chk("R10 load running", 32'(load_o), 32'h01);
        chk("R10 load value", load_val_o, 32'h1234_5678);
        idle(1); chk("R10 load one cycle", 32'(load_o), 0);
        wr(12'h020, 32'h0000_9999);
        chk("R10 load stopped", 32'(load_o), 0);

        // R11 interrupts
        wr(12'h030, 32'h0000_1007);
        idle(4);
        wr(12'h048, 32'h1);
        wr(12'h04C, 32'h2);
        expire(8'h01);
        chk("R11 ch0 toggles", 32'(irq_o), 32'h01);
        expire(8'h28);
        chk("R11 no toggle", 32'(irq_o), 32'h01);
        wr(12'h04C, 32'h0);
        expire(8'h08);
        chk("R11 ch3 zero match", 32'(irq_o), 32'h09);
        expire(8'h01);
        chk("R11 ch0 back", 32'(irq_o), 32'h08);

        // R12 read data holds
        rd(12'h030, 32'h0000_1007, "R5 ctrl final");
        idle(2);
        chk("R12 rdata held", rdata, 32'h0000_1007);

        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule